// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt requests from three sources into one status register: a disk controller, a DSP doorbell and a vertical blank signal. It drives one interrupt line to a host processor. When the processor runs an interrupt-acknowledge cycle, the block answers with a fixed 8-bit vector for the highest-priority pending source.

Each source has its own clear rule. The disk-controller bit is a copy of that controller's level request, so only the controller can drop it. The DSP bit and the vertical-blank bit are latched when their event occurs. They stay set until an acknowledge selects them. An acknowledge that finds nothing pending returns a spurious vector and raises an error flag for that answer.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `pending` is all zero and `cpu_irq`, `ack_valid`, `ack_vector` and `spurious` are all zero.
- R2: `pending[7]` (disk) takes the value of `disk_req` sampled at each clock edge. It follows the line both up and down, and an acknowledge never clears it.
- R3: A clock edge with `dsp_bell_wr` high sets `pending[4]` (DSP). The bit stays set until an acknowledge selects the DSP source.
- R4: `pending[5]` (vertical blank) is set only by a low-to-high transition of `vblank`. Holding `vblank` high or taking it low neither sets nor clears the bit.
- R5: `cpu_irq` is high in exactly those cycles in which any `pending` bit is set. The unused bits, including 1 and 2, read zero.
- R6: `ack_valid` pulses in the cycle after a cycle with `ack` high. In that same cycle `ack_vector` holds the vector of the highest-priority pending source: disk gives 11, else DSP gives 12, else vertical blank gives 13.
- R7: An acknowledge that selects the DSP or vertical-blank source clears that bit. The other bits are left unchanged.
- R8: An acknowledge with no bit pending returns `ack_vector` = 0 and raises `spurious` together with `ack_valid`.
- R9: If a set event and an acknowledge clear hit the same bit at the same edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disk_req | input | 1 | Level request from the disk controller |
| dsp_bell_wr | input | 1 | One-cycle strobe for a DSP doorbell write |
| vblank | input | 1 | Vertical blank level; only its rising edge counts |
| ack | input | 1 | Interrupt-acknowledge strobe from the host |
| pending | output | 8 | Status register: bit 7 disk, bit 5 vblank, bit 4 DSP |
| cpu_irq | output | 1 | Interrupt line to the host |
| ack_valid | output | 1 | Acknowledge answer is valid this cycle |
| ack_vector | output | 8 | Vector returned for the acknowledge |
| spurious | output | 1 | Acknowledge found nothing pending |

## Verification
The main sweep walks all eight combinations of pending disk, DSP and vertical-blank sources. For each one it issues an acknowledge and compares the vector, the spurious flag and the remaining status against values worked out from the priority order. This separates a wrong priority, a wrong vector constant, a clear on the wrong bit and a missing clear. Further patterns check the edge-versus-level behaviour. They hold `vblank` high across an acknowledge and then release it, and they raise and drop `disk_req` while acknowledges run. Set-during-clear collisions are driven for both latched sources, to show that the set wins.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DISK = 2'd1,
    SRC_DSP  = 2'd2,
    SRC_VBL  = 2'd3
  } irq_src_e;

  typedef struct packed {
    logic     hit;
    irq_src_e src;
  } irq_grant_t;

endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int STAT_W   = 8,
  parameter int DISK_BIT = 7,
  parameter int DSP_BIT  = 4,
  parameter int VBL_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disk_req,
  input  logic              dsp_bell,
  input  logic              vblank,
  input  logic              clr_dsp,
  input  logic              clr_vbl,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] status_d
);

  logic vbl_prev;
  logic vbl_rise;

  always_ff @(posedge clk) begin
    if (rst) vbl_prev <= 1'b0;
    else     vbl_prev <= vblank;
  end

  assign vbl_rise = vblank & ~vbl_prev;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == DISK_BIT) begin : g_level
      assign status_d[i] = disk_req;
    end else if (i == DSP_BIT) begin : g_dsp
      // a set on the same edge outranks the clear
      assign status_d[i] = dsp_bell | (status_q[i] & ~clr_dsp);
    end else if (i == VBL_BIT) begin : g_vbl
      assign status_d[i] = vbl_rise | (status_q[i] & ~clr_vbl);
    end else begin : g_unused
      assign status_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int VEC_W    = 8,
  parameter int DISK_BIT = 7,
  parameter int DSP_BIT  = 4,
  parameter int VBL_BIT  = 5,
  parameter int DISK_VEC = 11,
  parameter int DSP_VEC  = 12,
  parameter int VBL_VEC  = 13,
  parameter int NONE_VEC = 0
) (
  input  logic [STAT_W-1:0] status,
  output irq_grant_t        grant,
  output logic [VEC_W-1:0]  vector
);

  always_comb begin
    grant  = '{hit: 1'b0, src: SRC_NONE};
    vector = VEC_W'(NONE_VEC);
    if (status[DISK_BIT]) begin
      grant  = '{hit: 1'b1, src: SRC_DISK};
      vector = VEC_W'(DISK_VEC);
    end else if (status[DSP_BIT]) begin
      grant  = '{hit: 1'b1, src: SRC_DSP};
      vector = VEC_W'(DSP_VEC);
    end else if (status[VBL_BIT]) begin
      grant  = '{hit: 1'b1, src: SRC_VBL};
      vector = VEC_W'(VBL_VEC);
    end
  end

endmodule

// File: rtl/irqc_ack.sv
module irqc_ack
  import irqc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  irq_grant_t       grant,
  input  logic [VEC_W-1:0] vector_in,
  output logic             clr_dsp,
  output logic             clr_vbl,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vector,
  output logic             spurious
);

  assign clr_dsp = ack & grant.hit & (grant.src == SRC_DSP);
  assign clr_vbl = ack & grant.hit & (grant.src == SRC_VBL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid  <= 1'b0;
      ack_vector <= '0;
      spurious   <= 1'b0;
    end else begin
      ack_valid <= ack;
      spurious  <= ack & ~grant.hit;
      if (ack) ack_vector <= vector_in;
      else     ack_vector <= '0;
    end
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int VEC_W    = 8,
  parameter int DISK_BIT = 7,
  parameter int DSP_BIT  = 4,
  parameter int VBL_BIT  = 5,
  parameter int DISK_VEC = 11,
  parameter int DSP_VEC  = 12,
  parameter int VBL_VEC  = 13,
  parameter int NONE_VEC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disk_req,
  input  logic              dsp_bell_wr,
  input  logic              vblank,
  input  logic              ack,
  output logic [STAT_W-1:0] pending,
  output logic              cpu_irq,
  output logic              ack_valid,
  output logic [VEC_W-1:0]  ack_vector,
  output logic              spurious
);

  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] status_d;
  logic              clr_dsp;
  logic              clr_vbl;
  irq_grant_t        grant;
  logic [VEC_W-1:0]  vec_sel;

  irqc_status #(
    .STAT_W(STAT_W), .DISK_BIT(DISK_BIT), .DSP_BIT(DSP_BIT), .VBL_BIT(VBL_BIT)
  ) u_status (
    .clk(clk), .rst(rst), .disk_req(disk_req), .dsp_bell(dsp_bell_wr),
    .vblank(vblank), .clr_dsp(clr_dsp), .clr_vbl(clr_vbl),
    .status_q(status_q), .status_d(status_d)
  );

  irqc_prio #(
    .STAT_W(STAT_W), .VEC_W(VEC_W), .DISK_BIT(DISK_BIT), .DSP_BIT(DSP_BIT),
    .VBL_BIT(VBL_BIT), .DISK_VEC(DISK_VEC), .DSP_VEC(DSP_VEC),
    .VBL_VEC(VBL_VEC), .NONE_VEC(NONE_VEC)
  ) u_prio (
    .status(status_q), .grant(grant), .vector(vec_sel)
  );

  irqc_ack #(.VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst(rst), .ack(ack), .grant(grant), .vector_in(vec_sel),
    .clr_dsp(clr_dsp), .clr_vbl(clr_vbl), .ack_valid(ack_valid),
    .ack_vector(ack_vector), .spurious(spurious)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= |status_d;
  end

  assign pending = status_q;

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int STAT_W = 8,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              disk_req,
  input logic              dsp_bell_wr,
  input logic              vblank,
  input logic              ack,
  input logic [STAT_W-1:0] pending,
  input logic              cpu_irq,
  input logic              ack_valid,
  input logic [VEC_W-1:0]  ack_vector,
  input logic              spurious
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_disk_follow_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pending[7] == $past(disk_req)));

  p_bell_sets_r3: assert property (@(posedge clk) disable iff (rst)
    dsp_bell_wr |=> (pending[4] && cpu_irq));

  p_vbl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !ack && !pending[5] && $past(vblank) && vblank) |=> !pending[5]);

  p_irq_any_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (pending != '0));

  p_answer_r6: assert property (@(posedge clk) disable iff (rst)
    ack |=> ack_valid);

  p_disk_first_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && pending[7]) |=> (ack_vector == VEC_W'(11)));

  p_spur_r8: assert property (@(posedge clk) disable iff (rst)
    spurious |-> (ack_valid && ack_vector == '0));

  p_no_spur_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && pending != '0) |=> !spurious);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.STAT_W(STAT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .disk_req(disk_req), .dsp_bell_wr(dsp_bell_wr),
  .vblank(vblank), .ack(ack), .pending(pending), .cpu_irq(cpu_irq),
  .ack_valid(ack_valid), .ack_vector(ack_vector), .spurious(spurious)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disk_req = 1'b0;
  logic       dsp_bell_wr = 1'b0;
  logic       vblank = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] pending;
  logic       cpu_irq;
  logic       ack_valid;
  logic [7:0] ack_vector;
  logic       spurious;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst(rst), .disk_req(disk_req), .dsp_bell_wr(dsp_bell_wr),
    .vblank(vblank), .ack(ack), .pending(pending), .cpu_irq(cpu_irq),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .spurious(spurious)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; disk_req = 0; dsp_bell_wr = 0; vblank = 0; ack = 0;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();
    // R1 reset state
    chk("R1 pending", pending, 0);
    chk("R1 cpu_irq", cpu_irq, 0);
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 vector", ack_vector, 0);
    chk("R1 spurious", spurious, 0);

    // Sweep all pending combinations, one acknowledge each (R6 R7 R8 R5)
    for (int m = 0; m < 8; m++) begin
      automatic bit d = m[2];
      automatic bit p = m[1];
      automatic bit v = m[0];
      automatic int exp_pend = (d << 7) | (v << 5) | (p << 4);
      automatic int exp_vec = d ? 11 : (p ? 12 : (v ? 13 : 0));
      automatic int exp_after = exp_pend;
      if (!d && p) exp_after = exp_pend & ~(1 << 4);
      else if (!d && !p && v) exp_after = exp_pend & ~(1 << 5);
      do_reset();
      disk_req = d; dsp_bell_wr = p; vblank = v;
      step();
      dsp_bell_wr = 0; vblank = 0;
      chk("R5 pending set", pending, exp_pend);
      chk("R5 cpu_irq", cpu_irq, exp_pend != 0);
      ack = 1;
      step();
      ack = 0;
      chk("R6 ack_valid", ack_valid, 1);
      chk("R6 vector", ack_vector, exp_vec);
      chk("R8 spurious", spurious, exp_pend == 0);
      chk("R7 pending after ack", pending, exp_after);
      step();
      chk("R6 valid one cycle", ack_valid, 0);
    end

    // R2 disk follows level both ways
    do_reset();
    disk_req = 1; step();
    chk("R2 disk up", pending, 8'h80);
    ack = 1; step(); ack = 0;
    chk("R2 not cleared by ack", pending, 8'h80);
    disk_req = 0; step();
    chk("R2 disk down", pending, 0);
    chk("R5 irq low", cpu_irq, 0);

    // R3 doorbell latched
    do_reset();
    dsp_bell_wr = 1; step(); dsp_bell_wr = 0;
    step(); step();
    chk("R3 latched", pending, 8'h10);

    // R4 vblank edge only
    do_reset();
    vblank = 1; step();
    chk("R4 rise sets", pending, 8'h20);
    ack = 1; step(); ack = 0;
    chk("R4 ack vector", ack_vector, 13);
    chk("R4 cleared", pending, 0);
    step(); step();
    chk("R4 held high no reset", pending, 0);
    vblank = 0; step();
    chk("R4 fall no effect", pending, 0);
    vblank = 1; step();
    chk("R4 second rise", pending, 8'h20);
    vblank = 0; step();
    chk("R4 fall keeps bit", pending, 8'h20);

    // R9 set and clear collide: DSP
    do_reset();
    dsp_bell_wr = 1; step();
    ack = 1; step();
    ack = 0; dsp_bell_wr = 0;
    chk("R9 dsp vector", ack_vector, 12);
    chk("R9 dsp kept", pending, 8'h10);

    // R9 collide: vblank
    do_reset();
    vblank = 1; step(); vblank = 0; step();
    ack = 1; vblank = 1; step();
    ack = 0; vblank = 0;
    chk("R9 vbl vector", ack_vector, 13);
    chk("R9 vbl kept", pending, 8'h20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule